// File: doc/BRIEF.md
# Fixed-Latency Memory Subordinate

This block is a bus subordinate that sits behind a valid/ready request port and serves it from a local byte-addressable word array. A manager presents a word address, a write flag, per-byte enables, write data and a repeat hint. The block answers every accepted transfer with a read word and an error flag. The answer comes a fixed number of clock periods later. That number is a parameter and may be zero, which makes the path combinational, or one or two.

The same design covers three uses. A writable scratch memory updates only the enabled bytes. A read-only variant holds computed constant contents and refuses every write. A register-window variant rejects any access that does not enable every byte lane. A stall input lets a test environment pull the ready signal low. The repeat hint lets a manager re-fetch the word it read last without activating the array. The returned word stays on the output until the next real read replaces it.

Top module: `tcm_sub`

## Requirements
- R1: `req_rdy` is the inverse of `stall` when `USE_STALL` is 1 (constant 1 otherwise). A transfer happens in a clock period where `req_vld` and `req_rdy` are both high.
- R2: A write transfer (`req_wen`=1) that is not in error updates, at word `req_adr`, exactly the bytes whose `req_ben` bit is set. Bit b of `req_ben` covers `req_wdt[8b+7:8b]`. The other bytes keep their contents.
- R3: With `LAT`=1, a read transfer (`req_wen`=0, `req_rpt`=0, no error) returns the addressed word on `rsp_rdt` in the clock period after the transfer.
- R4: With `LAT`=0, the word read by a transfer appears on `rsp_rdt` and its status on `rsp_err` combinationally, in the same period as the transfer.
- R5: With `LAT`=2, both the read word and the status appear two clock periods after the transfer, through one extra register stage behind the held word.
- R6: A read transfer with `req_rpt`=1 does not read the array. Its response is the word already held from the last real read, even if that address was written since.
- R7: The held read word changes only on a real read transfer (`req_rpt`=0, no error). Idle periods, writes, repeats and rejected accesses leave `rsp_rdt` unchanged.
- R8: With `READ_ONLY`=1, each write transfer returns `rsp_err`=1 and changes no contents. The contents of word a are the low `DATA_W` bits of the 64-bit product (a+1)·0x9E3779B97F4A7C15.
- R9: With `FULL_ONLY`=1, a transfer whose `req_ben` is not all ones returns `rsp_err`=1. It neither writes the array nor updates the held word.
- R10: `rsp_err` is delivered with the same latency as read data. It is 1 exactly for rejected transfers. It is 0 for accepted reads, accepted writes and idle periods.
- R11: After reset the held word is zero, `rsp_rdt` is 0 and `rsp_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Test backpressure: forces ready low |
| req_vld | input | 1 | Request valid |
| req_rdy | output | 1 | Request ready |
| req_wen | input | 1 | 1 = write, 0 = read |
| req_rpt | input | 1 | Repeat hint: reuse the held read word |
| req_adr | input | ADDR_W | Word address |
| req_ben | input | DATA_W/SEL_W | Byte enables |
| req_wdt | input | DATA_W | Write data |
| rsp_rdt | output | DATA_W | Read data, held between reads |
| rsp_err | output | 1 | Error status of the transfer LAT periods earlier |

## Verification
The assertions take for granted that the manager follows the handshake rules. `req_vld` is low during reset. A request stays unchanged while it waits for ready. Every transfer is either a read or a write, never both. The stimulus keeps to these rules by issuing each request through one task. That task holds all request fields until the period in which the shared stall is low, and it keeps valid low during and right after reset. Three instances with different latency and mode parameters receive the same stimulus, so each ordering case hits all three variants in the same period.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    // Decision taken for the transfer in the current period.
    typedef struct packed {
        logic xfer;   // handshake completed
        logic bad;    // transfer rejected, error response
        logic wr_go;  // array write performed
        logic rd_go;  // array read performed, held word updated
    } tcm_act_t;

    // Constant contents of the read-only variant.
    function automatic logic [63:0] rom_pattern(input logic [63:0] a);
        return (a + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
    endfunction

endpackage

// File: rtl/tcm_req_check.sv
module tcm_req_check #(
    parameter int SEL_N     = 4,
    parameter bit READ_ONLY = 1'b0,
    parameter bit FULL_ONLY = 1'b0
) (
    input  logic             vld,
    input  logic             rdy,
    input  logic             wen,
    input  logic             rpt,
    input  logic [SEL_N-1:0] ben,
    output tcm_pkg::tcm_act_t act
);
    logic xfer;
    logic ro_hit;
    logic width_hit;

    assign xfer      = vld && rdy;
    assign ro_hit    = READ_ONLY && wen;
    assign width_hit = FULL_ONLY && (ben != {SEL_N{1'b1}});

    always_comb begin
        act.xfer  = xfer;
        act.bad   = xfer && (ro_hit || width_hit);
        act.wr_go = xfer && wen && !(ro_hit || width_hit);
        act.rd_go = xfer && !wen && !rpt && !width_hit;
    end
endmodule

// File: rtl/tcm_store.sv
module tcm_store #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 8,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [ADDR_W-1:0]       adr,
    input  logic [DATA_W/SEL_W-1:0] ben,
    input  logic [DATA_W-1:0]       wdt,
    output logic [DATA_W-1:0]       rd_now,
    output logic [DATA_W-1:0]       rd_hold
);
    localparam int SEL_N = DATA_W / SEL_W;
    localparam int DEPTH = 1 << ADDR_W;

    generate
        if (READ_ONLY) begin : g_rom
            logic unused_wr;
            assign unused_wr = ^{wr_go, ben, wdt};
            assign rd_now = DATA_W'(tcm_pkg::rom_pattern(64'(adr)));
        end else begin : g_ram
            logic [DATA_W-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
                for (int b = 0; b < SEL_N; b++) begin
                    if (wr_go && ben[b]) begin
                        mem[adr][b*SEL_W +: SEL_W] <= wdt[b*SEL_W +: SEL_W];
                    end
                end
            end
            assign rd_now = mem[adr];
        end
    endgenerate

    // Held read word: reused by repeat reads, kept until the next real read.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold <= '0;
        end else if (rd_go) begin
            rd_hold <= rd_now;
        end
    end

    // R7: no real read, no change of the held word
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rd_hold));
endmodule

// File: rtl/tcm_rsp_pipe.sv
module tcm_rsp_pipe #(
    parameter int DATA_W = 32,
    parameter int LAT    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fresh,
    input  logic              bad,
    input  logic [DATA_W-1:0] rd_now,
    input  logic [DATA_W-1:0] rd_hold,
    output logic [DATA_W-1:0] rdt,
    output logic              err
);
    generate
        if (LAT == 0) begin : g_lat0
            logic unused_ck;
            assign unused_ck = clk ^ rst;
            assign rdt = fresh ? rd_now : rd_hold;
            assign err = bad;
        end else if (LAT == 1) begin : g_lat1
            logic unused_in;
            logic err_q;
            assign unused_in = ^{fresh, rd_now};
            always_ff @(posedge clk) begin
                if (rst) err_q <= 1'b0;
                else     err_q <= bad;
            end
            assign rdt = rd_hold;
            assign err = err_q;

            // R10: status one period after the transfer
            a_r10_err_lat1: assert property (@(posedge clk) disable iff (rst)
                bad |=> err);
            a_r10_ok_lat1: assert property (@(posedge clk) disable iff (rst)
                !bad |=> !err);
        end else begin : g_lat2
            logic unused_in;
            logic [DATA_W-1:0] rdt_q;
            logic [1:0] err_q;
            assign unused_in = ^{fresh, rd_now};
            always_ff @(posedge clk) begin
                if (rst) begin
                    rdt_q <= '0;
                    err_q <= '0;
                end else begin
                    rdt_q <= rd_hold;
                    err_q <= {err_q[0], bad};
                end
            end
            assign rdt = rdt_q;
            assign err = err_q[1];

            // R5 / R10: status two periods after the transfer
            a_r5_err_lat2: assert property (@(posedge clk) disable iff (rst)
                bad |-> ##2 err);
            a_r10_ok_lat2: assert property (@(posedge clk) disable iff (rst)
                !bad |-> ##2 !err);
        end
    endgenerate
endmodule

// File: rtl/tcm_sub.sv
module tcm_sub #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 8,
    parameter int LAT       = 1,
    parameter bit READ_ONLY = 1'b0,
    parameter bit FULL_ONLY = 1'b0,
    parameter bit USE_STALL = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stall,
    input  logic                    req_vld,
    output logic                    req_rdy,
    input  logic                    req_wen,
    input  logic                    req_rpt,
    input  logic [ADDR_W-1:0]       req_adr,
    input  logic [DATA_W/SEL_W-1:0] req_ben,
    input  logic [DATA_W-1:0]       req_wdt,
    output logic [DATA_W-1:0]       rsp_rdt,
    output logic                    rsp_err
);
    localparam int SEL_N = DATA_W / SEL_W;

    tcm_pkg::tcm_act_t act;
    logic [DATA_W-1:0] rd_now;
    logic [DATA_W-1:0] rd_hold;

    assign req_rdy = !(USE_STALL && stall);

    tcm_req_check #(
        .SEL_N    (SEL_N),
        .READ_ONLY(READ_ONLY),
        .FULL_ONLY(FULL_ONLY)
    ) u_check (
        .vld(req_vld),
        .rdy(req_rdy),
        .wen(req_wen),
        .rpt(req_rpt),
        .ben(req_ben),
        .act(act)
    );

    tcm_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .READ_ONLY(READ_ONLY)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_go  (act.wr_go),
        .rd_go  (act.rd_go),
        .adr    (req_adr),
        .ben    (req_ben),
        .wdt    (req_wdt),
        .rd_now (rd_now),
        .rd_hold(rd_hold)
    );

    tcm_rsp_pipe #(
        .DATA_W(DATA_W),
        .LAT   (LAT)
    ) u_rsp (
        .clk    (clk),
        .rst    (rst),
        .fresh  (act.rd_go),
        .bad    (act.bad),
        .rd_now (rd_now),
        .rd_hold(rd_hold),
        .rdt    (rsp_rdt),
        .err    (rsp_err)
    );

    // R8: a write to the read-only variant is rejected and not performed
    a_r8_ro_reject: assert property (@(posedge clk) disable iff (rst)
        (READ_ONLY && req_vld && req_rdy && req_wen) |-> (act.bad && !act.wr_go));

    // R9: partial byte enables are rejected in full-width mode
    a_r9_partial_reject: assert property (@(posedge clk) disable iff (rst)
        (FULL_ONLY && req_vld && req_rdy && (req_ben != {SEL_N{1'b1}}))
            |-> (act.bad && !act.wr_go && !act.rd_go));

    // R6: a repeat read never activates the array read
    a_r6_rpt_no_read: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_rdy && !req_wen && req_rpt) |-> !act.rd_go);

    // R2 / R3: a transfer is a read or a write, never both
    a_r2_one_op: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act.wr_go, act.rd_go}));

    // R1: nothing happens without a completed handshake
    a_r1_no_xfer_no_op: assert property (@(posedge clk) disable iff (rst)
        !(req_vld && req_rdy) |-> !(act.wr_go || act.rd_go || act.bad));
endmodule

// File: tb/tcm_sub_tb_top.sv
module tcm_sub_tb_top;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int SN = 4;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 1'b0;
    logic vld = 1'b0;
    logic wen = 1'b0;
    logic rpt = 1'b0;
    logic [AW-1:0] adr = '0;
    logic [SN-1:0] ben = '0;
    logic [DW-1:0] wdt = '0;

    logic rdy_a, rdy_b, rdy_c;
    logic [DW-1:0] rdt_a, rdt_b, rdt_c;
    logic err_a, err_b, err_c;

    always #5 clk = ~clk;

    // writable, one period latency
    tcm_sub #(.ADDR_W(AW), .DATA_W(DW), .LAT(1)) dut_i (
        .clk(clk), .rst(rst), .stall(stall), .req_vld(vld), .req_rdy(rdy_a),
        .req_wen(wen), .req_rpt(rpt), .req_adr(adr), .req_ben(ben), .req_wdt(wdt),
        .rsp_rdt(rdt_a), .rsp_err(err_a));
    // writable, zero latency, full width only
    tcm_sub #(.ADDR_W(AW), .DATA_W(DW), .LAT(0), .FULL_ONLY(1'b1)) dut_z (
        .clk(clk), .rst(rst), .stall(stall), .req_vld(vld), .req_rdy(rdy_b),
        .req_wen(wen), .req_rpt(rpt), .req_adr(adr), .req_ben(ben), .req_wdt(wdt),
        .rsp_rdt(rdt_b), .rsp_err(err_b));
    // read-only, two period latency
    tcm_sub #(.ADDR_W(AW), .DATA_W(DW), .LAT(2), .READ_ONLY(1'b1)) dut_t (
        .clk(clk), .rst(rst), .stall(stall), .req_vld(vld), .req_rdy(rdy_c),
        .req_wen(wen), .req_rpt(rpt), .req_adr(adr), .req_ben(ben), .req_wdt(wdt),
        .rsp_rdt(rdt_c), .rsp_err(err_c));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string ctx = "R11 reset";

    // reference model state
    logic [DW-1:0] m_a [NW];
    logic [DW-1:0] m_b [NW];
    bit k_a [NW];
    bit k_b [NW];
    logic [DW-1:0] h_a = '0, h_b = '0, h_c = '0, hq_c = '0;
    bit hk_a = 1'b1, hk_b = 1'b1;
    bit bq_a = 1'b0, bq_c1 = 1'b0, bq_c2 = 1'b0;

    function automatic logic [DW-1:0] rom_exp(input int a);
        logic [63:0] p;
        p = (64'(a) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
        return p[DW-1:0];
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): got %h expected %h", tag, ctx, act, exp);
        end
    endtask

    // compare all outputs, then advance the model over the coming edge
    task automatic step();
        logic xfer, bad_b, fresh_b, bad_c, fresh_c;
        logic [DW-1:0] exp_b;
        bit ek_b;
        #1;
        xfer = vld && !stall;
        chk("R1 ready", 32'(rdy_a & rdy_b & rdy_c), 32'(!stall));
        // one period latency instance
        if (hk_a) chk("R3 data", rdt_a, h_a);
        chk("R10 err lat1", 32'(err_a), 32'(bq_a));
        // zero latency instance
        bad_b = xfer && (ben != 4'hF);
        fresh_b = xfer && !wen && !rpt && !bad_b;
        exp_b = fresh_b ? m_b[adr] : h_b;
        ek_b = fresh_b ? k_b[adr] : hk_b;
        if (ek_b) chk("R4 data", rdt_b, exp_b);
        chk(bad_b ? "R9 err" : "R10 err lat0", 32'(err_b), 32'(bad_b));
        // two period latency read-only instance
        chk("R5 data", rdt_c, hq_c);
        chk(bq_c2 ? "R8 err" : "R10 err lat2", 32'(err_c), 32'(bq_c2));
        // model update for instance a
        bq_a = 1'b0;
        if (xfer && !wen && !rpt) begin h_a = m_a[adr]; hk_a = k_a[adr]; end
        if (xfer && wen) begin
            for (int b = 0; b < SN; b++)
                if (ben[b]) m_a[adr][b*8 +: 8] = wdt[b*8 +: 8];
            if (ben == 4'hF) k_a[adr] = 1'b1;
        end
        // instance b
        if (fresh_b) begin h_b = m_b[adr]; hk_b = k_b[adr]; end
        if (xfer && wen && !bad_b) begin m_b[adr] = wdt; k_b[adr] = 1'b1; end
        // instance c
        bad_c = xfer && wen;
        fresh_c = xfer && !wen && !rpt;
        hq_c = h_c;
        if (fresh_c) h_c = rom_exp(int'(adr));
        bq_c2 = bq_c1;
        bq_c1 = bad_c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b0; stall = 1'b0; rpt = 1'b0; wen = 1'b0;
            step();
        end
    endtask

    // one request, held until accepted
    task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [SN-1:0] be,
                       input logic [DW-1:0] d, input logic r, input bit may_stall);
        bit taken = 1'b0;
        while (!taken) begin
            @(negedge clk);
            vld = 1'b1; wen = w; adr = a; ben = be; wdt = d; rpt = r;
            stall = may_stall ? ($urandom_range(3) == 0) : 1'b0;
            step();
            taken = !stall;
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin k_a[i] = 1'b0; k_b[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ctx = "R11 reset";
        idle(2);

        ctx = "R2 fill";
        for (int i = 0; i < NW; i++)
            cyc(1'b1, AW'(i), 4'hF, 32'(i) * 32'h0101_0101 ^ 32'h5A00_00A5, 1'b0, 1'b0);
        idle(1);

        ctx = "R2 byte enables";
        cyc(1'b1, 6'd5, 4'b0101, 32'hAABB_CCDD, 1'b0, 1'b0);
        cyc(1'b0, 6'd5, 4'hF, '0, 1'b0, 1'b0);
        idle(2);

        ctx = "R6 repeat";
        cyc(1'b0, 6'd7, 4'hF, '0, 1'b0, 1'b0);
        cyc(1'b1, 6'd7, 4'hF, 32'h1234_5678, 1'b0, 1'b0);
        cyc(1'b0, 6'd7, 4'hF, '0, 1'b1, 1'b0);
        idle(2);
        cyc(1'b0, 6'd7, 4'hF, '0, 1'b0, 1'b0);
        idle(2);

        ctx = "R7 hold";
        cyc(1'b0, 6'd9, 4'hF, '0, 1'b0, 1'b0);
        idle(3);
        cyc(1'b1, 6'd10, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0);
        idle(3);

        ctx = "R9 partial";
        cyc(1'b1, 6'd3, 4'b0011, 32'hFFFF_FFFF, 1'b0, 1'b0);
        cyc(1'b0, 6'd3, 4'b0001, '0, 1'b0, 1'b0);
        cyc(1'b0, 6'd3, 4'hF, '0, 1'b0, 1'b0);
        idle(2);

        ctx = "R8 read-only";
        cyc(1'b1, 6'd2, 4'hF, 32'h0BAD_F00D, 1'b0, 1'b0);
        cyc(1'b0, 6'd2, 4'hF, '0, 1'b0, 1'b0);
        idle(3);

        ctx = "R1 backpressure mix";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(4) == 0) begin
                idle(1);
            end else begin
                logic w;
                w = ($urandom_range(2) == 0);
                cyc(w, AW'($urandom), ($urandom_range(2) == 0) ? 4'hF : SN'($urandom),
                    $urandom, (!w && $urandom_range(3) == 0), 1'b1);
            end
        end
        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule